// File: doc/BRIEF.md
# Bus Slave Command and Format Controller

This block is the protocol state machine of a slave node on a two-wire single-master sensor bus. A front end delivers each received word after framing and CRC checking: the word bits, whether it was a long or a short word, whether its CRC was good, and which side of the node's bus switch it arrived on. The controller then does four things:

- It matches the word's 4-bit address field against the node's own address, with address 0 reaching every node.
- It runs the initialization handshake that assigns the node's address and closes its downstream bus switch. This lets the master number a daisy chain of nodes one at a time.
- It executes the clear command.
- It serves the format-control command, which reads and writes a small guarded register file. That file drives the CRC polynomial, CRC seed, CRC length and short-word length used by the framing logic.

Replies are never sent in the word that caused them. A reply is armed on the response port when the command word ends. It stays armed through the next command word, during which the transmitter shifts it out, and it is retired when that word ends.

Top module: `dnode_ctrl`

## Requirements
- R1: After reset the bus switch is open (`bus_sw_en`=0), no reply is armed (`tx_valid`=0), `fmt_active`=0, and the effective format outputs are the defaults: polynomial 0x11, seed 0x0A, CRC length 4, short length 8.
- R2: Initialization is accepted only when all of the following hold:
  - the node is uninitialized and the CRC is good;
  - the word is long, laid out as data in [15:8], address in [7:4] and command in [3:0];
  - either the command is 0000 and `rx_on_input`=1, or the command is 1111 (reverse form) and `rx_on_input`=0;
  - the target address in data[3:0] is nonzero;
  - the address field is 0 or equals the target.

  When accepted, the node adopts the target address, sets `bus_sw_en` to data[6], and arms a long reply that echoes the whole 16-bit word.
- R3: Once initialized, the node ignores any further initialization or reverse initialization: its address and switch do not change and no reply is armed.
- R4: An uninitialized node acts on nothing but initialization. It makes no reply and no format change.
- R5: A word whose CRC is flagged bad causes no action and no reply.
- R6: The reply registers update in the cycle after each `rx_valid` pulse and are held between pulses. A reply armed by one word stays valid until the next word ends, when it is replaced by that word's reply or dropped.
- R7: Clear and format control act only when the address field equals the node's address or is 0. A word with address field 0 never arms a reply, except for initialization.
- R8: A format-control word is long with command 1010. Its data byte carries write (bit 7 = 1), register select (bits 6:4) and value (bits 3:0). The reply to a specifically addressed command is {data[7:4], selected register value after the command, own address, 1010}.
- R9: A read (data bit 7 = 0) leaves the registers unchanged and replies with the current value; a read sent to address 0 is not honoured and arms no reply.
- R10: The following writes are ignored:
  - a write of more than 8 to the CRC-length register (select 4);
  - a write of less than 8 to the short-length register (select 5);
  - any write to select 6, which always reads 0.
- R11: Writing 1111 to select 7 makes the custom format active, and writing 0000 returns to the defaults; any other value leaves the selection unchanged. Select 7 reads 1111 when active and 0000 otherwise. While active the outputs are: polynomial {sel1, sel0}, seed {sel3, sel2}, CRC length sel4, short length sel5.
- R12: An addressed clear (command 0111, long or short) returns the node to the uninitialized state. The switch opens, selects 0 to 5 reload 0001, 0001, 1010, 0000, 0100 and 1000, the custom format is deactivated, and no reply is armed.
- R13: Format control sent as a short word is ignored, and so is initialization sent as a short word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle pulse: a received word is presented |
| rx_long | input | 1 | 1 = long word, 0 = short word |
| rx_crc_ok | input | 1 | CRC of the received word matched |
| rx_on_input | input | 1 | 1 = word arrived on the switch input side, 0 = output side |
| rx_word | input | 16 | Word bits: data [15:8], address [7:4], command [3:0] |
| tx_valid | output | 1 | A reply is armed for the current command word |
| tx_long | output | 1 | Armed reply is a long word |
| tx_word | output | 16 | Armed reply bits |
| bus_sw_en | output | 1 | Close request for the downstream bus switch |
| fmt_active | output | 1 | Custom format selected |
| fmt_poly | output | 8 | Effective CRC polynomial |
| fmt_seed | output | 8 | Effective CRC seed |
| fmt_crc_len | output | 4 | Effective CRC length |
| fmt_short_len | output | 4 | Effective short-word data length |

## Verification
The initialization handshake is tried with several kinds of word:
- words arriving on the wrong switch side, which separates the two initialization forms;
- words with a bad CRC, which separates discard from acceptance;
- a second initialization after the first, which tells one-shot behaviour from re-programming.

Format-control writes cover legal values, out-of-range lengths, the reserved select and non-uniform selection values. These show the guarded registers apart from plain storage, and staged values apart from the effective outputs. Sending the same commands to the node's own address, to a foreign address and to address 0, in both word lengths, separates address matching from global execution and from reply suppression. A clear followed by a reverse-form initialization on the other switch side shows that the full default state is restored.

// File: rtl/dnode_pkg.sv
package dnode_pkg;

  localparam int ADDR_W   = 4;
  localparam int CMD_W    = 4;
  localparam int DATA_W   = 8;
  localparam int NIB_W    = 4;
  localparam int WORD_W   = DATA_W + ADDR_W + CMD_W;
  localparam int SEL_W    = 3;
  localparam int FDATA_N  = 6;

  localparam logic [CMD_W-1:0] CMD_INIT  = 4'b0000;
  localparam logic [CMD_W-1:0] CMD_RINIT = 4'b1111;
  localparam logic [CMD_W-1:0] CMD_CLEAR = 4'b0111;
  localparam logic [CMD_W-1:0] CMD_FMT   = 4'b1010;

  localparam logic [SEL_W-1:0] SEL_CRCLEN = 3'd4;
  localparam logic [SEL_W-1:0] SEL_SHORT  = 3'd5;
  localparam logic [SEL_W-1:0] SEL_MODE   = 3'd7;

  localparam logic [NIB_W-1:0] CRCLEN_MAX   = 4'd8;
  localparam logic [NIB_W-1:0] SHORTLEN_MIN = 4'd8;
  localparam logic [NIB_W-1:0] MODE_ON      = 4'b1111;
  localparam logic [NIB_W-1:0] MODE_OFF     = 4'b0000;

  typedef struct packed {
    logic                take_init;
    logic                take_clear;
    logic                fmt_wr;
    logic                rsp_init;
    logic                rsp_fmt;
    logic [SEL_W-1:0]    sel;
    logic [NIB_W-1:0]    val;
    logic [ADDR_W-1:0]   new_addr;
    logic                sw_req;
  } dec_t;

  function automatic logic [NIB_W-1:0] freg_default(input int idx);
    case (idx)
      0:       return 4'b0001;
      1:       return 4'b0001;
      2:       return 4'b1010;
      3:       return 4'b0000;
      4:       return 4'b0100;
      5:       return 4'b1000;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic freg_legal(input int idx, input logic [NIB_W-1:0] v);
    case (idx)
      4:       return (v <= CRCLEN_MAX);
      5:       return (v >= SHORTLEN_MIN);
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/dnode_cmd_decode.sv
module dnode_cmd_decode
  import dnode_pkg::*;
(
  input  logic                 rx_valid,
  input  logic                 rx_long,
  input  logic                 rx_crc_ok,
  input  logic                 rx_on_input,
  input  logic [WORD_W-1:0]    rx_word,
  input  logic                 inited,
  input  logic [ADDR_W-1:0]    my_addr,
  output dec_t                 dec
);

  logic [DATA_W-1:0] f_data;
  logic [ADDR_W-1:0] f_addr;
  logic [CMD_W-1:0]  f_cmd;
  logic [ADDR_W-1:0] f_target;
  logic              word_ok;
  logic              side_ok;
  logic              is_global;
  logic              is_mine;

  assign f_data   = rx_word[WORD_W-1 -: DATA_W];
  assign f_addr   = rx_word[CMD_W +: ADDR_W];
  assign f_cmd    = rx_word[CMD_W-1:0];
  assign f_target = f_data[ADDR_W-1:0];

  assign word_ok   = rx_valid && rx_crc_ok;
  assign side_ok   = ((f_cmd == CMD_INIT) && rx_on_input) ||
                     ((f_cmd == CMD_RINIT) && !rx_on_input);
  assign is_global = (f_addr == '0);
  assign is_mine   = is_global || (f_addr == my_addr);

  always_comb begin
    dec = '0;
    if (word_ok && !inited) begin
      if (rx_long && side_ok && (f_target != '0) &&
          (is_global || (f_addr == f_target))) begin
        dec.take_init = 1'b1;
        dec.rsp_init  = 1'b1;
        dec.new_addr  = f_target;
        dec.sw_req    = f_data[6];
      end
    end else if (word_ok && is_mine) begin
      if (f_cmd == CMD_CLEAR) begin
        dec.take_clear = 1'b1;
      end else if ((f_cmd == CMD_FMT) && rx_long) begin
        dec.sel     = f_data[NIB_W +: SEL_W];
        dec.val     = f_data[NIB_W-1:0];
        dec.fmt_wr  = f_data[DATA_W-1];
        dec.rsp_fmt = !is_global;
      end
    end
  end

endmodule

// File: rtl/dnode_fmt_regs.sv
module dnode_fmt_regs
  import dnode_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          wr_en,
  input  logic [SEL_W-1:0]              sel,
  input  logic [NIB_W-1:0]              val,
  output logic [FDATA_N-1:0][NIB_W-1:0] nib_q,
  output logic                          active_q,
  output logic [NIB_W-1:0]              rd_next
);

  logic [FDATA_N-1:0][NIB_W-1:0] nib_d;
  logic                          active_d;
  logic                          mode_wr;

  for (genvar gi = 0; gi < FDATA_N; gi++) begin : g_nib
    localparam int IDX = gi;
    localparam logic [NIB_W-1:0] RST_V = freg_default(IDX);
    logic             hit;
    logic             en;
    logic [NIB_W-1:0] q;
    logic [NIB_W-1:0] d;

    assign hit = wr_en && (sel == IDX[SEL_W-1:0]) && freg_legal(IDX, val);
    assign en  = clr || hit;

    always_comb begin
      if (clr)      d = RST_V;
      else if (hit) d = val;
      else          d = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST_V;
      else if (en) q <= d;
    end

    assign nib_q[gi] = q;
    assign nib_d[gi] = d;
  end

  assign mode_wr = wr_en && (sel == SEL_MODE);

  always_comb begin
    active_d = active_q;
    if (clr)                             active_d = 1'b0;
    else if (mode_wr && val == MODE_ON)  active_d = 1'b1;
    else if (mode_wr && val == MODE_OFF) active_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= active_d;
  end

  always_comb begin
    rd_next = '0;
    if (sel == SEL_MODE) rd_next = {NIB_W{active_d}};
    for (int k = 0; k < FDATA_N; k++) begin
      if (sel == k[SEL_W-1:0]) rd_next = nib_d[k];
    end
  end

endmodule

// File: rtl/dnode_rsp_slot.sv
module dnode_rsp_slot
  import dnode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              load,
  input  logic              long_in,
  input  logic [WORD_W-1:0] word_in,
  output logic              tx_valid,
  output logic              tx_long,
  output logic [WORD_W-1:0] tx_word
);

  logic              valid_d;
  logic              data_en;

  assign valid_d = load;
  assign data_en = rx_valid && load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tx_valid <= 1'b0;
    else if (rx_valid) tx_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_long <= 1'b0;
      tx_word <= '0;
    end else if (data_en) begin
      tx_long <= long_in;
      tx_word <= word_in;
    end
  end

endmodule

// File: rtl/dnode_ctrl.sv
module dnode_ctrl
  import dnode_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_valid,
  input  logic                 rx_long,
  input  logic                 rx_crc_ok,
  input  logic                 rx_on_input,
  input  logic [15:0]          rx_word,
  output logic                 tx_valid,
  output logic                 tx_long,
  output logic [15:0]          tx_word,
  output logic                 bus_sw_en,
  output logic                 fmt_active,
  output logic [7:0]           fmt_poly,
  output logic [7:0]           fmt_seed,
  output logic [3:0]           fmt_crc_len,
  output logic [3:0]           fmt_short_len
);

  dec_t                          dec;
  logic                          inited_q, inited_d;
  logic [ADDR_W-1:0]             addr_q, addr_d;
  logic                          sw_q, sw_d;
  logic                          node_en;
  logic [FDATA_N-1:0][NIB_W-1:0] nib_q;
  logic                          active_q;
  logic [NIB_W-1:0]              rd_next;
  logic                          rsp_load;
  logic [WORD_W-1:0]             rsp_word;

  dnode_cmd_decode u_dec (
    .rx_valid    (rx_valid),
    .rx_long     (rx_long),
    .rx_crc_ok   (rx_crc_ok),
    .rx_on_input (rx_on_input),
    .rx_word     (rx_word),
    .inited      (inited_q),
    .my_addr     (addr_q),
    .dec         (dec)
  );

  // node state: next-state logic
  assign node_en = dec.take_clear || dec.take_init;

  always_comb begin
    inited_d = inited_q;
    addr_d   = addr_q;
    sw_d     = sw_q;
    if (dec.take_clear) begin
      inited_d = 1'b0;
      addr_d   = '0;
      sw_d     = 1'b0;
    end else if (dec.take_init) begin
      inited_d = 1'b1;
      addr_d   = dec.new_addr;
      sw_d     = dec.sw_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inited_q <= 1'b0;
      addr_q   <= '0;
      sw_q     <= 1'b0;
    end else if (node_en) begin
      inited_q <= inited_d;
      addr_q   <= addr_d;
      sw_q     <= sw_d;
    end
  end

  dnode_fmt_regs u_fmt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (dec.take_clear),
    .wr_en    (dec.fmt_wr),
    .sel      (dec.sel),
    .val      (dec.val),
    .nib_q    (nib_q),
    .active_q (active_q),
    .rd_next  (rd_next)
  );

  assign rsp_load = dec.rsp_init || dec.rsp_fmt;
  assign rsp_word = dec.rsp_init ? rx_word
                                 : {rx_word[WORD_W-1 -: NIB_W], rd_next, addr_q, CMD_FMT};

  dnode_rsp_slot u_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .load     (rsp_load),
    .long_in  (1'b1),
    .word_in  (rsp_word),
    .tx_valid (tx_valid),
    .tx_long  (tx_long),
    .tx_word  (tx_word)
  );

  assign bus_sw_en     = sw_q;
  assign fmt_active    = active_q;
  assign fmt_poly      = active_q ? {nib_q[1], nib_q[0]} : {freg_default(1), freg_default(0)};
  assign fmt_seed      = active_q ? {nib_q[3], nib_q[2]} : {freg_default(3), freg_default(2)};
  assign fmt_crc_len   = active_q ? nib_q[4] : freg_default(4);
  assign fmt_short_len = active_q ? nib_q[5] : freg_default(5);

endmodule

// File: rtl/dnode_ctrl_chk.sv
module dnode_ctrl_chk
  import dnode_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        rx_valid,
  input logic        rx_crc_ok,
  input logic [15:0] rx_word,
  input logic        tx_valid,
  input logic        bus_sw_en,
  input logic        fmt_active,
  input logic [3:0]  fmt_crc_len,
  input logic [3:0]  fmt_short_len,
  input logic        inited_q
);

  // R2: switch stays open until an initialization has been taken
  p_sw_needs_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !inited_q |-> !bus_sw_en);

  // R6: reply flag only moves after a received word
  p_rsp_on_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rx_valid) |-> $stable(tx_valid));

  // R5: a bad word arms nothing
  p_bad_crc_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_crc_ok) |=> !tx_valid);

  // R7: address 0 never draws a reply except for initialization
  p_global_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_word[7:4] == 4'h0 && rx_word[3:0] != CMD_INIT &&
     rx_word[3:0] != CMD_RINIT) |=> !tx_valid);

  // R4: uninitialized node answers nothing but initialization
  p_uninit_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !inited_q && rx_word[3:0] != CMD_INIT &&
     rx_word[3:0] != CMD_RINIT) |=> !tx_valid);

  // R12: an uninitialized node never runs a custom format
  p_uninit_default_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !inited_q |-> !fmt_active);

  // R10: effective lengths stay in their legal ranges
  p_len_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_crc_len <= 4'd8) && (fmt_short_len >= 4'd8));

endmodule

bind dnode_ctrl dnode_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rx_valid      (rx_valid),
  .rx_crc_ok     (rx_crc_ok),
  .rx_word       (rx_word),
  .tx_valid      (tx_valid),
  .bus_sw_en     (bus_sw_en),
  .fmt_active    (fmt_active),
  .fmt_crc_len   (fmt_crc_len),
  .fmt_short_len (fmt_short_len),
  .inited_q      (inited_q)
);

// File: tb/dnode_ctrl_tb.sv
module dnode_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        rx_valid, rx_long, rx_crc_ok, rx_on_input;
  logic [15:0] rx_word;
  logic        tx_valid, tx_long, bus_sw_en, fmt_active;
  logic [15:0] tx_word;
  logic [7:0]  fmt_poly, fmt_seed;
  logic [3:0]  fmt_crc_len, fmt_short_len;

  int n_checks = 0;
  int n_errors = 0;

  // behavioural reference state
  int m_init, m_addr, m_sw, m_act;
  int m_reg[6];
  int m_txv, m_txw, m_txl;

  dnode_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_long(rx_long),
    .rx_crc_ok(rx_crc_ok), .rx_on_input(rx_on_input), .rx_word(rx_word),
    .tx_valid(tx_valid), .tx_long(tx_long), .tx_word(tx_word),
    .bus_sw_en(bus_sw_en), .fmt_active(fmt_active), .fmt_poly(fmt_poly),
    .fmt_seed(fmt_seed), .fmt_crc_len(fmt_crc_len), .fmt_short_len(fmt_short_len)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int dflt(input int i);
    case (i)
      0: return 1;  1: return 1;  2: return 10;
      3: return 0;  4: return 4;  5: return 8;
      default: return 0;
    endcase
  endfunction

  task automatic model_reset();
    m_init = 0; m_addr = 0; m_sw = 0; m_act = 0; m_txv = 0;
    for (int i = 0; i < 6; i++) m_reg[i] = dflt(i);
  endtask

  function automatic int model_read(input int sel);
    if (sel < 6) return m_reg[sel];
    if (sel == 7) return m_act ? 15 : 0;
    return 0;
  endfunction

  task automatic model_step(input int lng, input int w, input int ok, input int side);
    int data, addr, cmd, pa, rw, sel, v;
    data = (w >> 8) & 255; addr = (w >> 4) & 15; cmd = w & 15; pa = data & 15;
    m_txv = 0;
    if (ok != 0) begin
      if (m_init == 0) begin
        if (lng != 0 && ((cmd == 0 && side != 0) || (cmd == 15 && side == 0)) &&
            pa != 0 && (addr == 0 || addr == pa)) begin
          m_init = 1; m_addr = pa; m_sw = (data >> 6) & 1;
          m_txv = 1; m_txw = w; m_txl = 1;
        end
      end else if (addr == 0 || addr == m_addr) begin
        if (cmd == 7) begin
          model_reset();
        end else if (cmd == 10 && lng != 0) begin
          rw = (data >> 7) & 1; sel = (data >> 4) & 7; v = data & 15;
          if (rw != 0) begin
            if (sel == 7) begin
              if (v == 15) m_act = 1;
              else if (v == 0) m_act = 0;
            end else if (sel == 4) begin
              if (v <= 8) m_reg[4] = v;
            end else if (sel == 5) begin
              if (v >= 8) m_reg[5] = v;
            end else if (sel < 6) begin
              m_reg[sel] = v;
            end
          end
          if (addr != 0) begin
            m_txv = 1; m_txl = 1;
            m_txw = ((data & 240) | model_read(sel)) * 256 + m_addr * 16 + 10;
          end
        end
      end
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R6 tx_valid", int'(tx_valid), m_txv);
    if (m_txv != 0) begin
      chk("R6 tx_word", int'(tx_word), m_txw);
      chk("R6 tx_long", int'(tx_long), m_txl);
    end
    chk("R2 bus_sw_en", int'(bus_sw_en), m_sw);
    chk("R11 fmt_active", int'(fmt_active), m_act);
    chk("R11 fmt_poly", int'(fmt_poly), m_act != 0 ? m_reg[1]*16 + m_reg[0] : 17);
    chk("R11 fmt_seed", int'(fmt_seed), m_act != 0 ? m_reg[3]*16 + m_reg[2] : 10);
    chk("R11 fmt_crc_len", int'(fmt_crc_len), m_act != 0 ? m_reg[4] : 4);
    chk("R11 fmt_short_len", int'(fmt_short_len), m_act != 0 ? m_reg[5] : 8);
  endtask

  task automatic send(input int lng, input int w, input int ok, input int side);
    @(negedge clk);
    compare_all();
    rx_valid    = 1'b1;
    rx_long     = (lng != 0);
    rx_word     = w[15:0];
    rx_crc_ok   = (ok != 0);
    rx_on_input = (side != 0);
    model_step(lng, w, ok, side);
    @(negedge clk);
    rx_valid = 1'b0;
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_errors++;
    $display("FAIL R6 watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_valid = 1'b0; rx_long = 1'b0; rx_crc_ok = 1'b0;
    rx_on_input = 1'b0; rx_word = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk("R1 sw", int'(bus_sw_en), 0);
    chk("R1 tx_valid", int'(tx_valid), 0);
    chk("R1 poly", int'(fmt_poly), 8'h11);
    chk("R1 seed", int'(fmt_seed), 8'h0A);
    chk("R1 crc_len", int'(fmt_crc_len), 4);
    chk("R1 short_len", int'(fmt_short_len), 8);

    // R4 uninitialized node ignores a format write
    send(1, 16'hC65A, 1, 1);
    chk("R4 no reply uninit", int'(tx_valid), 0);
    // R2 initialization on the wrong side
    send(1, 16'h4500, 1, 0);
    chk("R2 wrong side", int'(bus_sw_en), 0);
    // R5 bad CRC
    send(1, 16'h4500, 0, 1);
    chk("R5 bad crc sw", int'(bus_sw_en), 0);
    chk("R5 bad crc reply", int'(tx_valid), 0);
    // R13 short initialization
    send(0, 16'h4500, 1, 1);
    chk("R13 short init", int'(bus_sw_en), 0);
    // R2 good initialization, address 5, switch close
    send(1, 16'h4500, 1, 1);
    chk("R2 sw closed", int'(bus_sw_en), 1);
    chk("R2 reply armed", int'(tx_valid), 1);
    chk("R2 echo", int'(tx_word), 16'h4500);
    idle(3);
    chk("R6 reply held", int'(tx_valid), 1);
    send(1, 16'h0000, 0, 1);
    chk("R6 reply retired", int'(tx_valid), 0);
    // R3 second initialization ignored
    send(1, 16'h0700, 1, 1);
    chk("R3 no reply", int'(tx_valid), 0);
    send(1, 16'h405A, 1, 1);
    chk("R3 addr kept / R4 crc_len untouched", int'(tx_word), 16'h445A);
    // R8 writes
    send(1, 16'hC65A, 1, 1);
    chk("R8 write reply", int'(tx_word), 16'hC65A);
    chk("R11 staged not active", int'(fmt_crc_len), 4);
    // R10 limits
    send(1, 16'hC95A, 1, 1);
    chk("R10 crc len >8", int'(tx_word), 16'hC65A);
    send(1, 16'hD75A, 1, 1);
    chk("R10 short len <8", int'(tx_word), 16'hD85A);
    send(1, 16'hDC5A, 1, 1);
    chk("R8 short len ok", int'(tx_word), 16'hDC5A);
    send(1, 16'hE35A, 1, 1);
    chk("R10 reserved", int'(tx_word), 16'hE05A);
    send(1, 16'h835A, 1, 1);
    send(1, 16'h9A5A, 1, 1);
    send(1, 16'hA55A, 1, 1);
    send(1, 16'hBC5A, 1, 1);
    // R11 mode selection
    send(1, 16'hF55A, 1, 1);
    chk("R11 partial select", int'(fmt_active), 0);
    chk("R11 select reads", int'(tx_word), 16'hF05A);
    send(1, 16'hFF5A, 1, 1);
    chk("R11 active", int'(fmt_active), 1);
    chk("R11 poly", int'(fmt_poly), 8'hA3);
    chk("R11 seed", int'(fmt_seed), 8'hC5);
    chk("R11 crc len", int'(fmt_crc_len), 6);
    chk("R11 short len", int'(fmt_short_len), 12);
    // R9 reads
    send(1, 16'h200A, 1, 1);
    chk("R9 global read", int'(tx_valid), 0);
    send(1, 16'h205A, 1, 1);
    chk("R9 read value", int'(tx_word), 16'h255A);
    // R7 addressing
    send(1, 16'hC23A, 1, 1);
    chk("R7 foreign reply", int'(tx_valid), 0);
    chk("R7 foreign write", int'(fmt_crc_len), 6);
    send(1, 16'hC20A, 1, 1);
    chk("R7 global reply", int'(tx_valid), 0);
    chk("R7 global write", int'(fmt_crc_len), 2);
    // R13 short format
    send(0, 16'hC15A, 1, 1);
    chk("R13 short fmt", int'(fmt_crc_len), 2);
    // R11 back to defaults
    send(1, 16'hF05A, 1, 1);
    chk("R11 off", int'(fmt_crc_len), 4);
    chk("R11 off poly", int'(fmt_poly), 8'h11);
    send(1, 16'hFF5A, 1, 1);
    // R12 clear
    send(0, 16'h0037, 1, 1);
    chk("R12 foreign clear", int'(bus_sw_en), 1);
    send(0, 16'h0007, 1, 1);
    chk("R12 sw open", int'(bus_sw_en), 0);
    chk("R12 inactive", int'(fmt_active), 0);
    chk("R12 no reply", int'(tx_valid), 0);
    send(1, 16'hFF5A, 1, 1);
    chk("R4 after clear", int'(fmt_active), 0);
    // R2 reverse form
    send(1, 16'h099F, 1, 1);
    chk("R2 reverse wrong side", int'(tx_valid), 0);
    send(1, 16'h099F, 1, 0);
    chk("R2 reverse echo", int'(tx_word), 16'h099F);
    chk("R2 reverse sw", int'(bus_sw_en), 0);
    send(1, 16'h409A, 1, 1);
    chk("R12 defaults restored", int'(tx_word), 16'h449A);
    send(1, 16'h509A, 1, 1);
    chk("R12 short default", int'(tx_word), 16'h589A);
    idle(2);
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule